// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a stream of decimal digits, sent one bit per clock with the least significant bit first, into the matching excess-3 stream on the same schedule. Every four consecutive input bits form one digit. The block adds three to each digit and returns the four result bits in the same LSB-first order. Digits follow one another with no gap, and a synchronous reset realigns the block to the first bit of a digit.

A build parameter picks one of two forms. In the Mealy form the output bit is a combinational function of the current input bit and the state, so it is valid in the same cycle as its input bit. In the Moore form the output comes from a register loaded from the next state, so each result bit appears one clock after its input bit.

Top module: `bcd_xs3_serial`

## Requirements
- R1: For every digit 0 to 9, the four output bits of that digit, read LSB first, equal the digit plus three. Successive digits are converted back to back, and every four input bits start a new digit.
- R2: With `USE_MOORE` = 0, the output for an input bit is valid in the same clock cycle that the bit is presented, before the rising edge that consumes it.
- R3: With `USE_MOORE` = 1, the output for an input bit is valid in the cycle after the rising edge that consumes it, which is one clock later than in the Mealy form.
- R4: When `rst` is high at a rising edge, the block returns to its start state. The next bit presented is treated as bit 0 of a new digit, including when the reset arrives part way through a digit. In the Moore form `dout` is 0 after that edge. In the Mealy form `dout` then equals the inverse of `din`.
- R5: In the Mealy form, a 4-bit code from 10 to 15 produces (code + 3) modulo 16, and the digit alignment is kept.
- R6: In the Moore form, the code 15 (input bits 1,1,1,1) produces output bits 0,1,0,1, so the state reached after three ones still accepts a fourth one. The following digit is converted correctly. The code 10 produces 13.
- R7: The input bit sequence 0,0,1,0,1,0,0,1 (digits 4 then 9) produces the output sequence 1,1,1,0,0,0,1,1. In the Moore form this sequence is shifted by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the start state |
| din | input | 1 | Serial BCD input, LSB of each digit first |
| dout | output | 1 | Serial excess-3 output |

## Verification
The bench drives each input bit just after a falling edge and samples 1 ns later, away from the rising edge. At that sample point the Mealy instance must already show the result for the bit just driven. The Moore instance must show the result for the bit driven in the previous cycle, so the bench keeps the previous expected Moore bit in hand and compares against it. Reset is checked at the sample after the reset edge, with the first post-reset bit consumed on the following rising edge. That way a lost or extra bit at a digit boundary shows up as a misaligned digit.

// File: rtl/bcd_xs3_pkg.sv
package bcd_xs3_pkg;

  localparam int XS3_DIGIT_W = 4;
  localparam logic [XS3_DIGIT_W-1:0] XS3_OFFSET = 4'd3;

  // Moore state register, 4-bit encoding; start doubles as the end-of-digit
  // state that emits 0.
  typedef enum logic [3:0] {
    MS_START = 4'b0010,
    MS_P1O1  = 4'b0111,
    MS_P1O0  = 4'b0011,
    MS_P2A   = 4'b0110,
    MS_P2B   = 4'b0101,
    MS_P2C   = 4'b0001,
    MS_P3A   = 4'b1010,
    MS_P3B   = 4'b1011,
    MS_P3C   = 4'b1001,
    MS_END1  = 4'b0100
  } moore_st_e;

  function automatic logic moore_out(moore_st_e s);
    case (s)
      MS_P1O1, MS_P2A, MS_P2C, MS_P3B, MS_END1: moore_out = 1'b1;
      default:                                   moore_out = 1'b0;
    endcase
  endfunction

  function automatic moore_st_e moore_next(moore_st_e s, logic x);
    case (s)
      MS_START, MS_END1: moore_next = x ? MS_P1O0 : MS_P1O1;
      MS_P1O1:           moore_next = x ? MS_P2B  : MS_P2A;
      MS_P1O0:           moore_next = x ? MS_P2C  : MS_P2B;
      MS_P2A:            moore_next = x ? MS_P3B  : MS_P3A;
      MS_P2B, MS_P2C:    moore_next = x ? MS_P3C  : MS_P3B;
      MS_P3A, MS_P3B:    moore_next = x ? MS_END1 : MS_START;
      MS_P3C:            moore_next = MS_END1;  // a 1 here is not BCD; stay aligned
      default:           moore_next = MS_START;
    endcase
  endfunction

endpackage

// File: rtl/bcd_xs3_mealy_core.sv
module bcd_xs3_mealy_core
  import bcd_xs3_pkg::*;
#(
  parameter int DIGIT_W = XS3_DIGIT_W,
  parameter logic [DIGIT_W-1:0] OFFSET = XS3_OFFSET
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int POS_W = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DIGIT_W - 1);

  logic [POS_W-1:0] pos_q;
  logic             carry_q;
  logic             k_bit;
  logic             carry_d;

  assign k_bit   = OFFSET[pos_q];
  assign dout    = din ^ k_bit ^ carry_q;
  assign carry_d = (pos_q == LAST_POS) ? 1'b0
                 : ((din & k_bit) | (din & carry_q) | (k_bit & carry_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      pos_q   <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      carry_q <= carry_d;
    end
  end

  // R4: reset leaves the adder at bit 0 with no carry pending
  a_r4_mealy_reset_start: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pos_q == '0 && carry_q == 1'b0));

  // R1, R5: after the last bit of a digit the next bit is bit 0 with no carry
  a_r1_mealy_digit_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos_q == LAST_POS) |=> (pos_q == '0 && carry_q == 1'b0));

endmodule

// File: rtl/bcd_xs3_moore_core.sv
module bcd_xs3_moore_core
  import bcd_xs3_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  moore_st_e state_q;
  moore_st_e state_d;
  logic      dout_q;

  assign state_d = moore_next(state_q, din);
  assign dout    = dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MS_START;
      dout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dout_q  <= moore_out(state_d);
    end
  end

  // R4: reset gives start state and a low output
  a_r4_moore_reset_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == 1'b0 && state_q == MS_START));

  // R6: a 1 after three ones is absorbed into the end-of-digit state
  a_r6_moore_bad_bit: assert property (@(posedge clk) disable iff (rst)
    (state_q == MS_P3C && din) |=> (state_q == MS_END1 && dout == 1'b1));

  // R1: the fourth bit of every digit lands in one of the end states
  a_r1_moore_digit_end: assert property (@(posedge clk) disable iff (rst)
    (state_q == MS_P3A || state_q == MS_P3B || state_q == MS_P3C)
      |=> (state_q == MS_START || state_q == MS_END1));

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial #(
  parameter bit USE_MOORE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (USE_MOORE) begin : g_moore
      bcd_xs3_moore_core u_core (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(dout)
      );
    end else begin : g_mealy
      bcd_xs3_mealy_core u_core (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(dout)
      );
    end
  endgenerate
endmodule

// File: tb/bcd_xs3_serial_bench.sv
`timescale 1ns/1ps
module bcd_xs3_serial_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout_mealy;
  logic dout_moore;

  int n_checks = 0;
  int n_fail   = 0;
  logic prev_moore = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_xs3_serial #(.USE_MOORE(1'b0)) u_bcd_xs3_serial (
    .clk(clk), .rst(rst), .din(din), .dout(dout_mealy));

  bcd_xs3_serial #(.USE_MOORE(1'b1)) u_bcd_xs3_serial_moore (
    .clk(clk), .rst(rst), .din(din), .dout(dout_moore));

  task automatic chk(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Called at a falling edge: reset across one rising edge, return at the next falling edge.
  task automatic do_reset();
    rst = 1'b1;
    din = 1'b0;
    @(negedge clk);
    #1;
    chk(dout_moore, 1'b0, "R4 moore low after reset");
    chk(dout_mealy, 1'b1, "R4 mealy bit0 inverts din");
    rst = 1'b0;
    prev_moore = 1'b0;
  endtask

  // Drive one bit now; Mealy shows its result at once, Moore shows the previous one.
  task automatic send_bit(input logic b, input logic em, input logic eo, input string tag);
    din = b;
    #1;
    chk(dout_mealy, em, {tag, " mealy R2"});
    chk(dout_moore, prev_moore, {tag, " moore R3"});
    prev_moore = eo;
    @(negedge clk);
  endtask

  task automatic send_digit(input logic [3:0] d, input logic [3:0] em,
                            input logic [3:0] eo, input string tag);
    for (int i = 0; i < 4; i++) send_bit(d[i], em[i], eo[i], tag);
  endtask

  task automatic flush_moore(input string tag);
    #1;
    chk(dout_moore, prev_moore, {tag, " moore last bit R3"});
  endtask

  task automatic t_example();
    logic [7:0] ins  = 8'b1001_0100; // time order LSB first: 0,0,1,0,1,0,0,1
    logic [7:0] outs = 8'b1100_0111; // 1,1,1,0,0,0,1,1
    do_reset();
    for (int i = 0; i < 8; i++) send_bit(ins[i], outs[i], outs[i], "R7 example stream");
    flush_moore("R7");
  endtask

  task automatic t_all_digits();
    do_reset();
    for (int d = 0; d < 10; d++) begin
      logic [3:0] e = 4'(d + 3);
      send_digit(4'(d), e, e, "R1 digit");
    end
    for (int d = 9; d >= 0; d--) begin
      logic [3:0] e = 4'(d + 3);
      send_digit(4'(d), e, e, "R1 digit descending");
    end
    flush_moore("R1");
  endtask

  task automatic t_mid_reset();
    do_reset();
    send_bit(1'b1, 1'b0, 1'b0, "R4 partial digit");
    send_bit(1'b1, 1'b1, 1'b1, "R4 partial digit");
    do_reset();
    send_digit(4'd4, 4'd7, 4'd7, "R4 realigned digit");
    send_digit(4'd9, 4'd12, 4'd12, "R4 realigned digit");
    flush_moore("R4");
  endtask

  task automatic t_invalid();
    do_reset();
    send_digit(4'd15, 4'd2, 4'd10, "R5 R6 code 15");
    send_digit(4'd4, 4'd7, 4'd7, "R6 digit after code 15");
    send_digit(4'd10, 4'd13, 4'd13, "R5 R6 code 10");
    for (int d = 11; d < 15; d++) begin
      do_reset();
      send_digit(4'(d), 4'(d + 3), 4'(d + 3), "R5 mealy code");
    end
    do_reset();
    send_digit(4'd0, 4'd3, 4'd3, "R6 digit 0 after codes");
    flush_moore("R6");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk(dout_moore, 1'b0, "R4 moore held in reset");
    @(negedge clk);
    t_example();
    t_all_digits();
    t_mid_reset();
    t_invalid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule